// File: doc/BRIEF.md
# Programmable Interval Measurement Averager

This block takes a stream of signed, digitised voltage and current samples and produces one averaged measurement per interval. A two-bit mode field picks the quantity to average: the product of voltage and current (power), the voltage alone, or the current alone. The interval lasts 2^N milliseconds, with N taken from a four-bit field. One millisecond holds 2^SMP_PER_MS_LOG2 accepted samples, which is 1024 by default.

When an interval closes, the block divides the running sum by the sample count using an arithmetic right shift. It saturates the average to a count between -256 and +256 and loads it into a 16-bit result word as a left-aligned two's-complement value. A one-cycle strobe marks each update.

Configuration is sampled only when an interval starts, so a change made while an interval is running shapes the next interval. A shutdown input stops all accumulation. A clock-select input chooses which of two sample-valid strobes is counted: the one paced by the internal clock or the one paced by the external clock.

Top module: `ia_averager`

## Requirements
- R1: After reset, `result` is 0000h and `new_data` is low. The active configuration is N=0, mode power, internal strobe.
- R2: An interval closes on its 2^N * 2^SMP_PER_MS_LOG2-th accepted sample, and not before. Values of N above 8 are treated as 8.
- R3: Mode 00 (power) averages the per-sample term (voltage * current) >>> 8, where >>> is an arithmetic shift.
- R4: Mode 01 (voltage) averages the voltage samples. A negative voltage average is reported as 0.
- R5: Mode 10 (current) averages the current samples, and the sign is kept.
- R6: Mode 11 gives the same result as mode 00.
- R7: The average is the interval sum shifted right arithmetically by N+SMP_PER_MS_LOG2 bits, so it rounds toward minus infinity. It is then clamped to the range -256..+256.
- R8: `result` holds the count in bits 15..6 and zero in bits 5..0. +256 reads as 4000h and -256 reads as C000h.
- R9: `new_data` is high for exactly one cycle. That is the cycle after the edge that takes the closing sample, and `result` changes in that same cycle. At all other times `result` holds its value.
- R10: Changes to N, mode or clock select take effect only for the interval that starts after the current one closes. This includes a change presented together with the closing sample.
- R11: While `cfg_shutdown` is high, samples are ignored, no strobe is produced and `result` holds. Any partial sum is discarded. After release, a fresh interval starts with the configuration present at that time.
- R12: With `cfg_ext_clk` at 0, only `smp_valid_int` is counted. With it at 1, only `smp_valid_ext` is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_interval | input | 4 | Interval exponent N (2^N ms) |
| cfg_mode | input | 2 | 00 power, 01 voltage, 10 current, 11 as power |
| cfg_shutdown | input | 1 | 1 stops accumulation |
| cfg_ext_clk | input | 1 | 1 selects the external-clock sample strobe |
| smp_valid_int | input | 1 | Sample strobe, internal clock |
| smp_valid_ext | input | 1 | Sample strobe, external clock |
| smp_volt | input | SMP_W | Signed voltage sample, full scale 256 |
| smp_curr | input | SMP_W | Signed current sample, full scale 256 |
| result | output | 16 | Packed averaged count |
| new_data | output | 1 | One-cycle update strobe |

## Verification
Closing an interval and loading a new configuration can happen in the same cycle. To provoke this, the bench presents a new mode and interval length on exactly the edge that takes the closing sample. It then checks two things: the strobe in that interval still carries the old mode's average, and the following interval runs for the new length in the new mode. A second test asserts shutdown part-way through an interval and confirms that the discarded partial sum does not leak into the next result.

// File: rtl/ia_pkg.sv
package ia_pkg;
    typedef enum logic [1:0] {
        MODE_PWR = 2'b00,
        MODE_VLT = 2'b01,
        MODE_CUR = 2'b10,
        MODE_RSV = 2'b11
    } mode_e;
endpackage

// File: rtl/ia_quantity.sv
module ia_quantity
    import ia_pkg::*;
#(
    parameter int SMP_W   = 10,
    parameter int FS_LOG2 = 8,
    parameter int QW      = 2*SMP_W - FS_LOG2
) (
    input  mode_e                    mode,
    input  logic signed [SMP_W-1:0]  volt,
    input  logic signed [SMP_W-1:0]  curr,
    output logic signed [QW-1:0]     quant
);
    logic signed [2*SMP_W-1:0] prod;
    logic signed [2*SMP_W-1:0] prod_sc;

    always_comb begin
        prod    = volt * curr;
        prod_sc = prod >>> FS_LOG2;
        case (mode)
            MODE_VLT: quant = QW'(volt);
            MODE_CUR: quant = QW'(curr);
            default:  quant = prod_sc[QW-1:0];
        endcase
    end
endmodule

// File: rtl/ia_scale_pack.sv
module ia_scale_pack
    import ia_pkg::*;
#(
    parameter int AW      = 31,
    parameter int SHW     = 5,
    parameter int FS_LOG2 = 8,
    parameter int RES_W   = 16
) (
    input  logic signed [AW-1:0] acc_sum,
    input  logic [SHW-1:0]       shift,
    input  mode_e                mode,
    output logic [RES_W-1:0]     word
);
    localparam int CW  = FS_LOG2 + 2;
    localparam int PAD = RES_W - CW;
    localparam logic signed [AW-1:0] POS_FS = AW'(2**FS_LOG2);
    localparam logic signed [AW-1:0] NEG_FS = -POS_FS;

    logic signed [AW-1:0] shifted;
    logic signed [AW-1:0] clamped;

    always_comb begin
        shifted = acc_sum >>> shift;
        if (shifted > POS_FS)      clamped = POS_FS;
        else if (shifted < NEG_FS) clamped = NEG_FS;
        else                       clamped = shifted;
        if (mode == MODE_VLT && clamped < 0) clamped = '0;
        word = {clamped[CW-1:0], {PAD{1'b0}}};
    end
endmodule

// File: rtl/ia_averager.sv
module ia_averager
    import ia_pkg::*;
#(
    parameter int SMP_W           = 10,
    parameter int SMP_PER_MS_LOG2 = 10,
    parameter int N_MAX           = 8,
    parameter int N_W             = 4,
    parameter int FS_LOG2         = 8,
    parameter int RES_W           = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_W-1:0]          cfg_interval,
    input  logic [1:0]              cfg_mode,
    input  logic                    cfg_shutdown,
    input  logic                    cfg_ext_clk,
    input  logic                    smp_valid_int,
    input  logic                    smp_valid_ext,
    input  logic signed [SMP_W-1:0] smp_volt,
    input  logic signed [SMP_W-1:0] smp_curr,
    output logic [RES_W-1:0]        result,
    output logic                    new_data
);
    localparam int QW    = 2*SMP_W - FS_LOG2;
    localparam int CNT_W = SMP_PER_MS_LOG2 + N_MAX;
    localparam int AW    = QW + CNT_W + 1;
    localparam int SHW   = $clog2(CNT_W + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    acc;
        logic [N_W-1:0]   n;
        mode_e            mode;
        logic             ext;
        logic [RES_W-1:0] res;
        logic             strobe;
    } state_t;

    state_t state_q, state_d;
    logic   past_ok_q;

    logic signed [QW-1:0] q_smp;
    logic signed [AW-1:0] acc_cur;
    logic signed [AW-1:0] acc_sum;
    logic [SHW-1:0]       shift;
    logic [CNT_W:0]       span;
    logic [CNT_W-1:0]     last;
    logic [RES_W-1:0]     packed_word;
    logic [N_W-1:0]       n_in;
    logic                 take;

    ia_quantity #(.SMP_W(SMP_W), .FS_LOG2(FS_LOG2), .QW(QW)) u_quant (
        .mode  (state_q.mode),
        .volt  (smp_volt),
        .curr  (smp_curr),
        .quant (q_smp)
    );

    ia_scale_pack #(.AW(AW), .SHW(SHW), .FS_LOG2(FS_LOG2), .RES_W(RES_W)) u_pack (
        .acc_sum (acc_sum),
        .shift   (shift),
        .mode    (state_q.mode),
        .word    (packed_word)
    );

    always_comb begin
        acc_cur = state_q.acc;
        acc_sum = acc_cur + AW'(q_smp);
        shift   = SHW'(state_q.n) + SHW'(SMP_PER_MS_LOG2);
        span    = (CNT_W+1)'(1) << shift;
        last    = CNT_W'(span - 1'b1);
        n_in    = (cfg_interval > N_W'(N_MAX)) ? N_W'(N_MAX) : cfg_interval;
        take    = state_q.ext ? smp_valid_ext : smp_valid_int;

        state_d        = state_q;
        state_d.strobe = 1'b0;
        if (cfg_shutdown) begin
            state_d.cnt  = '0;
            state_d.acc  = '0;
            state_d.n    = n_in;
            state_d.mode = mode_e'(cfg_mode);
            state_d.ext  = cfg_ext_clk;
        end else if (take) begin
            if (state_q.cnt == last) begin
                state_d.res    = packed_word;
                state_d.strobe = 1'b1;
                state_d.cnt    = '0;
                state_d.acc    = '0;
                state_d.n      = n_in;
                state_d.mode   = mode_e'(cfg_mode);
                state_d.ext    = cfg_ext_clk;
            end else begin
                state_d.cnt = state_q.cnt + 1'b1;
                state_d.acc = acc_sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= '{cnt: '0, acc: '0, n: '0, mode: MODE_PWR,
                           ext: 1'b0, res: '0, strobe: 1'b0};
            past_ok_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            past_ok_q <= 1'b1;
        end
    end

    assign result   = state_q.res;
    assign new_data = state_q.strobe;

    // R9
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_data |=> !new_data);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok_q)
        !new_data |-> $stable(result));

    // R11
    shutdown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shutdown |=> !new_data);

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.cnt <= last);

    // R7
    result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_data |-> ($signed(result) <= $signed(16'h4000)) &&
                     ($signed(result) >= $signed(16'hC000)));
endmodule

// File: tb/ia_averager_tb.sv
module ia_averager_tb;
    localparam int SMP_W = 10;
    localparam int L     = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] cfg_interval = '0;
    logic [1:0] cfg_mode = '0;
    logic cfg_shutdown = 1'b0;
    logic cfg_ext_clk = 1'b0;
    logic smp_valid_int = 1'b0;
    logic smp_valid_ext = 1'b0;
    logic signed [SMP_W-1:0] smp_volt = '0;
    logic signed [SMP_W-1:0] smp_curr = '0;
    logic [15:0] result;
    logic new_data;

    int tests = 0;
    int fails = 0;
    int early = 0;
    logic use_ext = 1'b0;

    always #4 clk = ~clk;

    ia_averager #(.SMP_W(SMP_W), .SMP_PER_MS_LOG2(L)) u_dut (
        .clk, .rst_n, .cfg_interval, .cfg_mode, .cfg_shutdown, .cfg_ext_clk,
        .smp_valid_int, .smp_valid_ext, .smp_volt, .smp_curr, .result, .new_data
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_cfg(int n, int mode, logic ext);
        @(negedge clk);
        cfg_interval = 4'(n);
        cfg_mode     = 2'(mode);
        cfg_ext_clk  = ext;
        use_ext      = ext;
    endtask

    task automatic restart();
        @(negedge clk) cfg_shutdown = 1'b1;
        @(negedge clk) cfg_shutdown = 1'b0;
    endtask

    // Drive cnt samples, then one idle cycle where new_data/result are observable.
    task automatic drive(int cnt, int v, int i, int step);
        early = 0;
        for (int k = 0; k < cnt; k++) begin
            @(negedge clk);
            if (new_data) early++;
            smp_volt = SMP_W'(v);
            smp_curr = SMP_W'(i + k*step);
            smp_valid_int = !use_ext;
            smp_valid_ext = use_ext;
        end
        @(negedge clk);
        smp_valid_int = 1'b0;
        smp_valid_ext = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 result", result, 16'h0000);
        chk("R1 strobe", 16'(new_data), 16'h0000);
        drive(8, 128, 200, 0);
        chk("R1 default power/N=0", {result[15:1], new_data}, {16'h1900 >> 1, 1'b1} );
    endtask

    task automatic t_modes();
        set_cfg(0, 0, 0); restart();
        drive(8, 128, 200, 0);
        chk("R3 power", result, 16'h1900);
        chk("R9 strobe", 16'(new_data), 16'h0001);
        chk("R9 no early strobe", 16'(early), 16'h0000);
        set_cfg(1, 1, 0); restart();
        drive(16, 256, 0, 0);
        chk("R8 voltage full scale", result, 16'h4000);
        set_cfg(0, 2, 0); restart();
        drive(8, 0, -300, 0);
        chk("R7 R8 current neg clamp", result, 16'hC000);
        drive(8, 0, 400, 0);
        chk("R7 current pos clamp", result, 16'h4000);
        set_cfg(0, 1, 0); restart();
        drive(8, -50, 0, 0);
        chk("R4 negative voltage to zero", result, 16'h0000);
        set_cfg(0, 3, 0); restart();
        drive(8, 64, -128, 0);
        chk("R6 mode 11 as power", result, 16'hF800);
        set_cfg(0, 2, 0); restart();
        drive(8, 0, 1, 1);
        chk("R5 R7 ramp floor pos", result, 16'h0100);
        drive(8, 0, -1, -1);
        chk("R5 R7 ramp floor neg", result, 16'hFEC0);
    endtask

    task automatic t_length();
        set_cfg(8, 2, 0); restart();
        drive(2047, 0, 100, 0);
        chk("R2 N=8 not yet", 16'(new_data + early), 16'h0000);
        drive(1, 0, 100, 0);
        chk("R2 N=8 closes", {result[15:1], new_data}, {16'h1900 >> 1, 1'b1});
        set_cfg(9, 2, 0); restart();
        drive(2047, 0, 60, 0);
        chk("R2 N=9 clamps to 8", 16'(new_data + early), 16'h0000);
        drive(1, 0, 60, 0);
        chk("R2 N=9 closes at 8", {result[15:1], new_data}, {16'h0F00 >> 1, 1'b1});
    endtask

    task automatic t_deferred();
        set_cfg(0, 0, 0); restart();
        drive(3, 128, 200, 0);
        set_cfg(1, 1, 0);
        drive(5, 128, 200, 0);
        chk("R10 old mode kept", result, 16'h1900);
        drive(8, 200, 0, 0);
        chk("R10 new length", 16'(new_data + early), 16'h0000);
        drive(8, 200, 0, 0);
        chk("R10 new mode", result, 16'h3200);
        // change presented with the closing sample
        set_cfg(0, 0, 0); restart();
        drive(7, 128, 200, 0);
        @(negedge clk);
        smp_volt = 10'sd128; smp_curr = 10'sd200; smp_valid_int = 1'b1;
        cfg_mode = 2'd2; cfg_interval = 4'd1;
        @(negedge clk);
        smp_valid_int = 1'b0;
        chk("R10 coincident old result", {result[15:1], new_data}, {16'h1900 >> 1, 1'b1});
        drive(16, 0, -40, 0);
        chk("R10 coincident new cfg", {result[15:1], new_data}, {16'hF600 >> 1, 1'b1});
        chk("R10 coincident no early", 16'(early), 16'h0000);
    endtask

    task automatic t_shutdown();
        set_cfg(0, 2, 0); restart();
        drive(8, 0, 120, 0);
        drive(4, 0, 100, 0);
        @(negedge clk) cfg_shutdown = 1'b1;
        drive(8, 0, 100, 0);
        chk("R11 no strobe in shutdown", 16'(new_data + early), 16'h0000);
        chk("R11 result held", result, 16'h1E00);
        @(negedge clk) cfg_shutdown = 1'b0;
        drive(8, 0, -40, 0);
        chk("R11 partial discarded", {result[15:1], new_data}, {16'hF600 >> 1, 1'b1});
    endtask

    task automatic t_clksel();
        set_cfg(0, 2, 1); restart();
        use_ext = 1'b0;
        drive(8, 0, 50, 0);
        chk("R12 internal ignored", 16'(new_data + early), 16'h0000);
        use_ext = 1'b1;
        drive(8, 0, 50, 0);
        chk("R12 external counted", {result[15:1], new_data}, {16'h0C80 >> 1, 1'b1});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_length();
        t_deferred();
        t_shutdown();
        t_clksel();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule